// File: doc/BRIEF.md
# DMA Descriptor Fetch and Load Unit

This unit prepares a DMA channel for its next piece of work. When a load is requested, either at channel start or when the row-completion logic asks for the next descriptor, it decodes the flow mode and the descriptor word count from the channel's config register. It then reads that many 16-bit descriptor words, one at a time, over a simple request/acknowledge read port. Each word lands in one of the channel's programmed registers according to a fixed slot order that depends on the flow mode. Finally it seeds the working registers: current address, current descriptor pointer and the current X and Y counts.

Along the way it derives the element size from the word-size field. It raises the error flag when the start address is not a multiple of that size, or when the flow mode and word count are not a legal combination. An illegal combination stops the load before any read is issued and leaves the channel not running. Software programs the registers through a 16-bit write port while the unit is idle. The data mover and the 2D stepping logic that consume the working registers sit outside this unit.

Top module: `dma_desc_loader`

## Requirements
- R1: After reset, busy, run, error and the read request are low, and every programmed and working register output reads zero.
- R2: Config fields: flow mode in bits 14:12 (0 stop, 1 autobuffer, 4 array, 6 small list, 7 large list), descriptor word count in bits 11:8, and word size in bits 3:2. For the word size, 2'b10 gives 4 bytes, 2'b01 gives 2 bytes, and 2'b00 or 2'b11 gives 1 byte; `elem_bytes_o` shows the result.
- R3: An illegal load raises the error flag, clears run and issues no reads. A load is illegal when the flow code is not in the list above, when stop or autobuffer has a nonzero word count, when array has a count outside 1..7, when small has a count outside 1..8, or when large has a count outside 1..9.
- R4: Array mode reads from the current descriptor pointer; small and large modes read from the next descriptor pointer. Successive words come from addresses 2 bytes apart. A word is taken only in a cycle where both `rd_req_o` and `rd_ack_i` are high, and exactly the configured number of words is read.
- R5: In large mode, word 0 loads the low half of the next descriptor pointer and word 1 loads the high half.
- R6: In small mode, word 0 loads only the low half of the next descriptor pointer; the high half keeps its programmed value.
- R7: The words after any link words load, in this order: start address low, start address high, config, X count, X modify, Y count, Y modify. Registers past the configured count keep their values.
- R8: At the end of a legal load, the current descriptor pointer takes the next pointer and the current address takes the start address. The current X and Y counts take the programmed counts, with a zero count replaced by 0xFFFF, and run is set.
- R9: The misalignment test uses the config and start address in effect when the load was requested. A misaligned start address sets the error flag, and the load still completes.
- R10: `busy_o` rises in the cycle after an accepted load request and falls on the same edge that writes the working registers. A load request while busy is ignored.
- R11: Write selects: 0/1 next pointer low/high, 2/3 start address low/high, 4 config, 5 X count, 6 X modify, 7 Y count, 8 Y modify, 9/10 current descriptor pointer low/high, 11 status clear. Every write is ignored while busy.
- R12: A write to select 11 clears the error flag when data bit 0 is 1 and clears run when data bit 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_req_i | input | 1 | Request a descriptor load |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 4 | Register write select |
| wr_data_i | input | 16 | Register write data |
| rd_req_o | output | 1 | Descriptor read request |
| rd_addr_o | output | 32 | Descriptor word byte address |
| rd_ack_i | input | 1 | Read accepted, data valid this cycle |
| rd_data_i | input | 16 | Descriptor word |
| busy_o | output | 1 | Load in progress |
| run_o | output | 1 | Channel running status |
| err_o | output | 1 | Error status |
| elem_bytes_o | output | 3 | Element size in bytes |
| next_ptr_o | output | 32 | Next descriptor pointer |
| start_addr_o | output | 32 | Start address |
| cfg_o | output | 16 | Config register |
| x_count_o | output | 16 | Programmed X count |
| x_mod_o | output | 16 | Programmed X modify |
| y_count_o | output | 16 | Programmed Y count |
| y_mod_o | output | 16 | Programmed Y modify |
| cur_desc_o | output | 32 | Current descriptor pointer |
| cur_addr_o | output | 32 | Current address |
| cur_x_o | output | 16 | Current X count |
| cur_y_o | output | 16 | Current Y count |

## Verification
The assertions check the read-port protocol on every cycle: a stalled request holds its address, and an accepted word moves the address on by 2. They also check that no programmed register moves during a load except on an accepted read, and that a request from idle raises busy. At every falling edge of busy they relate run to the current address and pointer, or to the error flag. The slot order for each flow mode, the choice of fetch pointer, the zero-count substitution, the misalignment rule and the individual illegal mode/count combinations depend on descriptor contents. Only the directed scenarios, which check the final register values and the number of reads, can show those.

// File: rtl/dfl_pkg.sv
package dfl_pkg;

    localparam int FLOW_LSB = 12;
    localparam int NW_LSB   = 8;
    localparam int WS_LSB   = 2;
    localparam int NW_W     = 4;
    localparam int SEL_W    = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_FETCH = 2'd2,
        ST_FINAL = 2'd3
    } dfl_state_e;

    typedef enum logic [2:0] {
        FLOW_STOP  = 3'd0,
        FLOW_AUTO  = 3'd1,
        FLOW_ARRAY = 3'd4,
        FLOW_SMALL = 3'd6,
        FLOW_LARGE = 3'd7
    } flow_e;

    typedef enum logic [1:0] {
        LINK_NONE  = 2'd0,
        LINK_SHORT = 2'd1,
        LINK_LONG  = 2'd2
    } link_e;

    localparam logic [SEL_W-1:0] SLOT_NXT_LO = 4'd0;
    localparam logic [SEL_W-1:0] SLOT_NXT_HI = 4'd1;
    localparam logic [SEL_W-1:0] SLOT_SA_LO  = 4'd2;
    localparam logic [SEL_W-1:0] SLOT_SA_HI  = 4'd3;
    localparam logic [SEL_W-1:0] SLOT_CFG    = 4'd4;
    localparam logic [SEL_W-1:0] SLOT_XC     = 4'd5;
    localparam logic [SEL_W-1:0] SLOT_XM     = 4'd6;
    localparam logic [SEL_W-1:0] SLOT_YC     = 4'd7;
    localparam logic [SEL_W-1:0] SLOT_YM     = 4'd8;
    localparam logic [SEL_W-1:0] SLOT_CDP_LO = 4'd9;
    localparam logic [SEL_W-1:0] SLOT_CDP_HI = 4'd10;
    localparam logic [SEL_W-1:0] SLOT_STAT   = 4'd11;

endpackage

// File: rtl/dfl_cfg_decode.sv
module dfl_cfg_decode
    import dfl_pkg::*;
#(
    parameter int MAX_WORDS = 9
) (
    input  logic [2:0]      flow_i,
    input  logic [NW_W-1:0] nwords_i,
    input  logic [1:0]      wsize_i,
    input  logic [1:0]      addr_lsb_i,
    output logic            legal_o,
    output link_e           link_o,
    output logic            from_cur_o,
    output logic [2:0]      elem_o,
    output logic            misalign_o
);

    localparam int ARRAY_MAX = MAX_WORDS - 2;
    localparam int SMALL_MAX = MAX_WORDS - 1;

    int nw;
    assign nw = int'(nwords_i);

    always_comb begin
        legal_o    = 1'b0;
        link_o     = LINK_NONE;
        from_cur_o = 1'b0;
        case (flow_i)
            FLOW_STOP, FLOW_AUTO: legal_o = (nw == 0);
            FLOW_ARRAY: begin
                legal_o    = (nw >= 1) && (nw <= ARRAY_MAX);
                from_cur_o = 1'b1;
            end
            FLOW_SMALL: begin
                legal_o = (nw >= 1) && (nw <= SMALL_MAX);
                link_o  = LINK_SHORT;
            end
            FLOW_LARGE: begin
                legal_o = (nw >= 1) && (nw <= MAX_WORDS);
                link_o  = LINK_LONG;
            end
            default: legal_o = 1'b0;
        endcase
    end

    always_comb begin
        case (wsize_i)
            2'b10:   elem_o = 3'd4;
            2'b01:   elem_o = 3'd2;
            default: elem_o = 3'd1;
        endcase
    end

    always_comb begin
        case (elem_o)
            3'd4:    misalign_o = |addr_lsb_i;
            3'd2:    misalign_o = addr_lsb_i[0];
            default: misalign_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/dfl_desc_route.sv
module dfl_desc_route
    import dfl_pkg::*;
(
    input  link_e            link_i,
    input  logic [NW_W-1:0]  idx_i,
    output logic [SEL_W-1:0] slot_o
);

    logic [SEL_W-1:0] idx_ext;
    assign idx_ext = SEL_W'(idx_i);

    always_comb begin
        case (link_i)
            LINK_LONG:  slot_o = idx_ext;
            LINK_SHORT: slot_o = (idx_ext == '0) ? SLOT_NXT_LO : idx_ext + SEL_W'(1);
            default:    slot_o = idx_ext + SEL_W'(2);
        endcase
    end

endmodule

// File: rtl/dma_desc_loader.sv
module dma_desc_loader
    import dfl_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int MAX_WORDS = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_req_i,
    input  logic                  wr_en_i,
    input  logic [SEL_W-1:0]      wr_sel_i,
    input  logic [WORD_W-1:0]     wr_data_i,
    output logic                  rd_req_o,
    output logic [2*WORD_W-1:0]   rd_addr_o,
    input  logic                  rd_ack_i,
    input  logic [WORD_W-1:0]     rd_data_i,
    output logic                  busy_o,
    output logic                  run_o,
    output logic                  err_o,
    output logic [2:0]            elem_bytes_o,
    output logic [2*WORD_W-1:0]   next_ptr_o,
    output logic [2*WORD_W-1:0]   start_addr_o,
    output logic [WORD_W-1:0]     cfg_o,
    output logic [WORD_W-1:0]     x_count_o,
    output logic [WORD_W-1:0]     x_mod_o,
    output logic [WORD_W-1:0]     y_count_o,
    output logic [WORD_W-1:0]     y_mod_o,
    output logic [2*WORD_W-1:0]   cur_desc_o,
    output logic [2*WORD_W-1:0]   cur_addr_o,
    output logic [WORD_W-1:0]     cur_x_o,
    output logic [WORD_W-1:0]     cur_y_o
);

    localparam int ADDR_W = 2 * WORD_W;

    typedef struct packed {
        dfl_state_e        st;
        logic [NW_W-1:0]   idx;
        logic [NW_W-1:0]   nwords;
        link_e             link;
        logic [ADDR_W-1:0] faddr;
        logic [ADDR_W-1:0] nxt;
        logic [ADDR_W-1:0] sa;
        logic [WORD_W-1:0] cfg;
        logic [WORD_W-1:0] xc;
        logic [WORD_W-1:0] xm;
        logic [WORD_W-1:0] yc;
        logic [WORD_W-1:0] ym;
        logic [ADDR_W-1:0] cdp;
        logic [ADDR_W-1:0] cad;
        logic [WORD_W-1:0] cx;
        logic [WORD_W-1:0] cy;
        logic [2:0]        elem;
        logic              run;
        logic              err;
    } regs_t;

    regs_t q, d;

    // Configuration decode of the current config and start address
    logic             dec_legal;
    link_e            dec_link;
    logic             dec_from_cur;
    logic [2:0]       dec_elem;
    logic             dec_mis;
    logic [SEL_W-1:0] slot;

    dfl_cfg_decode #(.MAX_WORDS(MAX_WORDS)) u_dec (
        .flow_i     (q.cfg[FLOW_LSB +: 3]),
        .nwords_i   (q.cfg[NW_LSB +: NW_W]),
        .wsize_i    (q.cfg[WS_LSB +: 2]),
        .addr_lsb_i (q.sa[1:0]),
        .legal_o    (dec_legal),
        .link_o     (dec_link),
        .from_cur_o (dec_from_cur),
        .elem_o     (dec_elem),
        .misalign_o (dec_mis)
    );

    dfl_desc_route u_route (
        .link_i (q.link),
        .idx_i  (q.idx),
        .slot_o (slot)
    );

    // Place one 16-bit value into the register named by sel
    function automatic regs_t put_word(input regs_t r, input logic [SEL_W-1:0] sel,
                                       input logic [WORD_W-1:0] val);
        regs_t o;
        o = r;
        case (sel)
            SLOT_NXT_LO: o.nxt[WORD_W-1:0]      = val;
            SLOT_NXT_HI: o.nxt[ADDR_W-1:WORD_W] = val;
            SLOT_SA_LO:  o.sa[WORD_W-1:0]       = val;
            SLOT_SA_HI:  o.sa[ADDR_W-1:WORD_W]  = val;
            SLOT_CFG:    o.cfg                  = val;
            SLOT_XC:     o.xc                   = val;
            SLOT_XM:     o.xm                   = val;
            SLOT_YC:     o.yc                   = val;
            SLOT_YM:     o.ym                   = val;
            SLOT_CDP_LO: o.cdp[WORD_W-1:0]      = val;
            SLOT_CDP_HI: o.cdp[ADDR_W-1:WORD_W] = val;
            SLOT_STAT: begin
                if (val[0]) o.err = 1'b0;
                if (val[1]) o.run = 1'b0;
            end
            default: ;
        endcase
        return o;
    endfunction

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (wr_en_i) d = put_word(d, wr_sel_i, wr_data_i);
                if (load_req_i) d.st = ST_CHECK;
            end
            ST_CHECK: begin
                d.elem   = dec_elem;
                d.link   = dec_link;
                d.nwords = q.cfg[NW_LSB +: NW_W];
                d.idx    = '0;
                d.faddr  = dec_from_cur ? q.cdp : q.nxt;
                if (dec_mis) d.err = 1'b1;
                if (!dec_legal) begin
                    d.err = 1'b1;
                    d.run = 1'b0;
                    d.st  = ST_IDLE;
                end else if (q.cfg[NW_LSB +: NW_W] == '0) begin
                    d.st = ST_FINAL;
                end else begin
                    d.st = ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (rd_ack_i) begin
                    d       = put_word(q, slot, rd_data_i);
                    d.faddr = q.faddr + ADDR_W'(2);
                    d.idx   = q.idx + NW_W'(1);
                    if (q.idx == q.nwords - NW_W'(1)) d.st = ST_FINAL;
                end
            end
            ST_FINAL: begin
                d.cdp = q.nxt;
                d.cad = q.sa;
                d.cx  = (q.xc == '0) ? '1 : q.xc;
                d.cy  = (q.yc == '0) ? '1 : q.yc;
                d.run = 1'b1;
                d.st  = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_req_o     = (q.st == ST_FETCH);
    assign rd_addr_o    = q.faddr;
    assign busy_o       = (q.st != ST_IDLE);
    assign run_o        = q.run;
    assign err_o        = q.err;
    assign elem_bytes_o = q.elem;
    assign next_ptr_o   = q.nxt;
    assign start_addr_o = q.sa;
    assign cfg_o        = q.cfg;
    assign x_count_o    = q.xc;
    assign x_mod_o      = q.xm;
    assign y_count_o    = q.yc;
    assign y_mod_o      = q.ym;
    assign cur_desc_o   = q.cdp;
    assign cur_addr_o   = q.cad;
    assign cur_x_o      = q.cx;
    assign cur_y_o      = q.cy;

endmodule

// File: rtl/dfl_checker.sv
module dfl_checker #(
    parameter int WORD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                load_req_i,
    input logic                rd_req_o,
    input logic                rd_ack_i,
    input logic [2*WORD_W-1:0] rd_addr_o,
    input logic                busy_o,
    input logic                run_o,
    input logic                err_o,
    input logic [WORD_W-1:0]   cfg_o,
    input logic [WORD_W-1:0]   x_count_o,
    input logic [2*WORD_W-1:0] start_addr_o,
    input logic [2*WORD_W-1:0] next_ptr_o,
    input logic [2*WORD_W-1:0] cur_addr_o,
    input logic [2*WORD_W-1:0] cur_desc_o
);

    // R4
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> busy_o);

    // R4
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_ack_i) |=> (!rd_req_o || rd_addr_o == $past(rd_addr_o) + 2));

    // R11
    busy_write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(rd_req_o && rd_ack_i)) |=>
            ($stable(cfg_o) && $stable(x_count_o) && $stable(start_addr_o)));

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req_i && !busy_o) |=> busy_o);

    // R8
    final_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && run_o) |-> (cur_addr_o == start_addr_o && cur_desc_o == next_ptr_o));

    // R3
    abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !run_o) |-> err_o);

endmodule

bind dma_desc_loader dfl_checker #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/dma_desc_loader_bench.sv
module dma_desc_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_req_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [3:0]  wr_sel_i = '0;
    logic [15:0] wr_data_i = '0;
    logic        rd_req_o;
    logic [31:0] rd_addr_o;
    logic        rd_ack_i = 1'b0;
    logic [15:0] rd_data_i = '0;
    logic        busy_o, run_o, err_o;
    logic [2:0]  elem_bytes_o;
    logic [31:0] next_ptr_o, start_addr_o, cur_desc_o, cur_addr_o;
    logic [15:0] cfg_o, x_count_o, x_mod_o, y_count_o, y_mod_o, cur_x_o, cur_y_o;

    int tests = 0;
    int fails = 0;
    int reads = 0;
    logic [31:0] first_addr;
    logic stall = 1'b0;
    logic tgl = 1'b0;
    logic [15:0] mem [0:63];

    always #2 clk = ~clk;

    dma_desc_loader u_dma_desc_loader (.*);

    // Memory responder: decides the handshake half a cycle before the edge
    always @(negedge clk) begin
        tgl = ~tgl;
        rd_ack_i  = rd_req_o && (!stall || tgl);
        rd_data_i = mem[rd_addr_o[6:1]];
        if (rd_req_o && rd_ack_i) begin
            if (reads == 0) first_addr = rd_addr_o;
            reads = reads + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] sel, input logic [15:0] val);
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = val;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
        chk("R10 load ends", {31'b0, busy_o}, 32'd0);
    endtask

    task automatic load();
        reads = 0;
        first_addr = '0;
        @(negedge clk);
        load_req_i = 1'b1;
        @(negedge clk);
        load_req_i = 1'b0;
        chk("R10 busy after request", {31'b0, busy_o}, 32'd1);
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1 busy", {31'b0, busy_o}, 0);
        chk("R1 run/err/req", {29'b0, run_o, err_o, rd_req_o}, 0);
        chk("R1 regs", next_ptr_o | start_addr_o | cur_addr_o | cur_desc_o, 0);
        chk("R1 counts", {cfg_o | x_count_o, cur_x_o | cur_y_o}, 0);
    endtask

    task automatic t_large();
        mem[8] = 16'h0040; mem[9] = 16'h0000; mem[10] = 16'h2000; mem[11] = 16'h0003;
        mem[12] = 16'h1234; mem[13] = 16'h0005; mem[14] = 16'h0004; mem[15] = 16'h0000;
        mem[16] = 16'h0008;
        wr(4'd0, 16'h0010); wr(4'd1, 16'h0000);
        wr(4'd2, 16'h0100); wr(4'd3, 16'h0000);
        wr(4'd4, 16'h7908);
        load();
        chk("R4 large read count", reads, 9);
        chk("R4 large fetch from next ptr", first_addr, 32'h10);
        chk("R5 large link", next_ptr_o, 32'h40);
        chk("R7 large start", start_addr_o, 32'h0003_2000);
        chk("R7 large cfg", cfg_o, 16'h1234);
        chk("R7 large x/xm", {x_count_o, x_mod_o}, {16'd5, 16'd4});
        chk("R7 large y/ym", {y_count_o, y_mod_o}, {16'd0, 16'd8});
        chk("R8 large cur desc", cur_desc_o, 32'h40);
        chk("R8 large cur addr", cur_addr_o, 32'h0003_2000);
        chk("R8 large cur x/y", {cur_x_o, cur_y_o}, {16'd5, 16'hFFFF});
        chk("R2 elem 4", elem_bytes_o, 4);
        chk("R8 run/err", {run_o, err_o}, 2'b10);
    endtask

    task automatic t_small();
        mem[16] = 16'h0060; mem[17] = 16'h0302; mem[18] = 16'h0004;
        wr(4'd0, 16'h0020); wr(4'd1, 16'h00AB);
        wr(4'd5, 16'h0000);
        wr(4'd4, 16'h6304);
        load();
        chk("R4 small read count", reads, 3);
        chk("R4 small fetch from next ptr", first_addr, 32'h00AB_0020);
        chk("R6 small link low only", next_ptr_o, 32'h00AB_0060);
        chk("R7 small start", start_addr_o, 32'h0004_0302);
        chk("R7 small cfg kept", cfg_o, 16'h6304);
        chk("R8 small zero counts", {cur_x_o, cur_y_o}, {16'hFFFF, 16'hFFFF});
        chk("R2 elem 2", elem_bytes_o, 2);
    endtask

    task automatic t_array_stall();
        mem[24] = 16'h0008; mem[25] = 16'h0001; mem[26] = 16'h4008; mem[27] = 16'h0003;
        mem[28] = 16'h0004; mem[29] = 16'h0002; mem[30] = 16'h0010;
        wr(4'd9, 16'h0030); wr(4'd10, 16'h0000);
        wr(4'd0, 16'h0050); wr(4'd1, 16'h0000);
        wr(4'd4, 16'h4704);
        stall = 1'b1;
        load();
        stall = 1'b0;
        chk("R4 array read count", reads, 7);
        chk("R4 array fetch from cur ptr", first_addr, 32'h30);
        chk("R7 array start", start_addr_o, 32'h0001_0008);
        chk("R7 array cfg", cfg_o, 16'h4008);
        chk("R7 array counts", {x_count_o, x_mod_o, y_count_o, y_mod_o}, {16'd3, 16'd4, 16'd2, 16'h10});
        chk("R8 array cur desc", cur_desc_o, 32'h50);
        chk("R8 array cur x/y", {cur_x_o, cur_y_o}, {16'd3, 16'd2});
        chk("R9 aligned no err", {31'b0, err_o}, 0);
    endtask

    task automatic t_ignore_busy();
        wr(4'd9, 16'h0030); wr(4'd10, 16'h0000);
        wr(4'd5, 16'h0007);
        wr(4'd4, 16'h4200);
        stall = 1'b1;
        reads = 0;
        @(negedge clk); load_req_i = 1'b1;
        @(negedge clk); load_req_i = 1'b0;
        @(negedge clk);
        wr_en_i = 1'b1; wr_sel_i = 4'd5; wr_data_i = 16'h0099; load_req_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; load_req_i = 1'b0;
        wait_idle();
        stall = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 write ignored while busy", x_count_o, 16'h0007);
        chk("R11 cur x from kept count", cur_x_o, 16'h0007);
        chk("R10 request while busy ignored", reads, 2);
        chk("R10 stays idle", {31'b0, busy_o}, 0);
        chk("R2 elem 1", elem_bytes_o, 1);
    endtask

    task automatic t_stop_misalign();
        wr(4'd11, 16'h0003);
        chk("R12 status cleared", {run_o, err_o}, 2'b00);
        wr(4'd2, 16'h0101); wr(4'd3, 16'h0000);
        wr(4'd5, 16'h0010); wr(4'd7, 16'h0000);
        wr(4'd4, 16'h0004);
        load();
        chk("R9 misaligned sets err", {31'b0, err_o}, 1);
        chk("R9 load still runs", {31'b0, run_o}, 1);
        chk("R8 stop no reads", reads, 0);
        chk("R8 stop cur addr", cur_addr_o, 32'h0101);
        chk("R8 stop cur x", cur_x_o, 16'h0010);
        wr(4'd11, 16'h0001);
        chk("R12 clear err only", {run_o, err_o}, 2'b10);
    endtask

    task automatic t_bad(input logic [15:0] cfg, input string tag);
        wr(4'd11, 16'h0001);
        wr(4'd2, 16'h0100);
        wr(4'd4, cfg);
        load();
        chk({"R3 ", tag, " err/run"}, {run_o, err_o}, 2'b01);
        chk({"R3 ", tag, " no reads"}, reads, 0);
        wr(4'd11, 16'h0001);
        wr(4'd4, 16'h1000);
        load();
        chk({"R3 ", tag, " auto recovers"}, {run_o, err_o}, 2'b10);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'(i);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_large();
        t_small();
        t_array_stall();
        t_ignore_busy();
        t_stop_misalign();
        t_bad(16'h2000, "flow2");
        t_bad(16'h0100, "stop n1");
        t_bad(16'h4800, "array n8");
        t_bad(16'h6900, "small n9");
        t_bad(16'h7A00, "large n10");
        t_bad(16'h7000, "large n0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule